// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Outputs

A four-bit synchronous counter that counts up or down on the rising clock edge. A build parameter selects one of two sequences: binary, 0 through 15, or decade, 0 through 9. An active-low load input presets the count from four data inputs. The load acts at once and does not wait for the clock. An active-low enable gates counting. A direction input selects the sense of the count.

Two outputs support chaining stages. The terminal flag is active high and marks the last value of the sequence in the current direction. The ripple output is active low and pulses during the low phase of the clock. It only pulses while the flag is set and counting is enabled, so its rising edge can clock the next stage.

In decade mode, a preset of 10 to 15 is an illegal state. The counter leaves it on the next enabled edge.

Top module: `udc_counter`

## Requirements
- R1: While `load_ni` is low, `q_o` equals `data_i` within the same clock phase, with no clock edge needed. The value is taken when `load_ni` falls.
- R2: While `load_ni` stays low, rising clock edges do not move `q_o` away from `data_i`, even with counting enabled.
- R3: With `load_ni` high, `en_ni` low and `down_i` low (up), each rising edge adds one. In binary mode 15 wraps to 0.
- R4: With `load_ni` high, `en_ni` low and `down_i` high (down), each rising edge subtracts one. In binary mode 0 wraps to 15.
- R5: With `en_ni` high, rising edges leave `q_o` unchanged.
- R6: `max_min_o` is high only when `q_o` holds the terminal value for the present direction, otherwise low. The terminal value is 15 (binary) or 9 (decade) when counting up, and 0 when counting down. An enabled edge in the same direction always leaves that value, so the flag lasts one cycle.
- R7: `rco_no` is low exactly while `clk_i` is low, `max_min_o` is high and `en_ni` is low. It is high at all other times, including when a disabled stage sits at its terminal value.
- R8: In decade mode, up counting goes from 9 to 0 and down counting goes from 0 to 9.
- R9: In decade mode, from any value 10 to 15 the next enabled edge goes to 0 when counting up and to 9 when counting down. `max_min_o` stays low while the count is in 10 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge active |
| load_ni | input | 1 | Asynchronous preset, active low |
| data_i | input | WIDTH | Preset value |
| en_ni | input | 1 | Count enable, active low |
| down_i | input | 1 | Direction: 1 down, 0 up |
| q_o | output | WIDTH | Current count |
| max_min_o | output | 1 | Terminal-value flag, active high |
| rco_no | output | 1 | Ripple clock for the next stage, active low |

## Verification
The illegal decade states 10 to 15 can only be reached through the asynchronous preset. The bench therefore loads each of them in turn, in mid low phase, and follows it with enabled edges in both directions, so that both the exit target and the low flag are observed. The ripple output depends on the clock level itself, so it is sampled once inside each high phase and once inside each low phase. A stage parked at its terminal value with enable high shows that the flag can be set without any ripple pulse.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  localparam int unsigned DEC_TOP = 9;
endpackage

// File: rtl/udc_next.sv
module udc_next #(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             down_i,
  output logic [WIDTH-1:0] nxt_o
);
  import udc_pkg::*;

  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(DEC_TOP) : {WIDTH{1'b1}};

  dir_e dir;
  assign dir = dir_e'(down_i);

  always_comb begin
    if (dir == DIR_UP) begin
      // at or past top (illegal decade values included) restart at zero
      nxt_o = (q_i >= TOP) ? '0 : q_i + WIDTH'(1);
    end else begin
      if (q_i == '0)     nxt_o = TOP;
      else if (q_i > TOP) nxt_o = TOP;
      else               nxt_o = q_i - WIDTH'(1);
    end
  end
endmodule

// File: rtl/udc_term.sv
module udc_term #(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic             clk_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] q_i,
  input  logic             down_i,
  input  logic             en_ni,
  output logic             max_min_o,
  output logic             rco_no
);
  import udc_pkg::*;

  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(DEC_TOP) : {WIDTH{1'b1}};

  logic at_top, at_zero;
  assign at_top  = (q_i == TOP);
  assign at_zero = (q_i == '0);

  assign max_min_o = (dir_e'(down_i) == DIR_DOWN) ? at_zero : at_top;
  // pulse only in low phase, only from an enabled stage
  assign rco_no = ~(max_min_o & ~en_ni & ~clk_i);

  // low phase sampled just before each rising edge
  p_rco_low_phase_r7: assert property (@(posedge clk_i) disable iff (!load_ni)
    (!rco_no) == (max_min_o && !en_ni));
endmodule

// File: rtl/udc_reg.sv
module udc_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge load_ni) begin
    if (!load_ni)    q_o <= data_i;
    else if (step_i) q_o <= nxt_i;
  end

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!load_ni)
    !step_i |=> $stable(q_o));

  p_load_follow_r1: assert property (@(negedge clk_i)
    !load_ni |-> (q_o == data_i));
endmodule

// File: rtl/udc_counter.sv
module udc_counter #(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic             clk_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_ni,
  input  logic             down_i,
  output logic [WIDTH-1:0] q_o,
  output logic             max_min_o,
  output logic             rco_no
);
  import udc_pkg::*;

  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(DEC_TOP) : {WIDTH{1'b1}};

  logic [WIDTH-1:0] nxt;

  udc_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
    .q_i    (q_o),
    .down_i (down_i),
    .nxt_o  (nxt)
  );

  udc_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i   (clk_i),
    .load_ni (load_ni),
    .data_i  (data_i),
    .step_i  (~en_ni),
    .nxt_i   (nxt),
    .q_o     (q_o)
  );

  udc_term #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
    .clk_i     (clk_i),
    .load_ni   (load_ni),
    .q_i       (q_o),
    .down_i    (down_i),
    .en_ni     (en_ni),
    .max_min_o (max_min_o),
    .rco_no    (rco_no)
  );

  p_count_up_r3: assert property (@(posedge clk_i) disable iff (!load_ni)
    (!en_ni && !down_i && q_o < TOP) |=> (q_o == $past(q_o) + WIDTH'(1)));

  p_wrap_up_r8: assert property (@(posedge clk_i) disable iff (!load_ni)
    (!en_ni && !down_i && q_o == TOP) |=> (q_o == '0));

  p_count_down_r4: assert property (@(posedge clk_i) disable iff (!load_ni)
    (!en_ni && down_i && q_o != '0 && q_o <= TOP) |=> (q_o == $past(q_o) - WIDTH'(1)));

  p_wrap_down_r4: assert property (@(posedge clk_i) disable iff (!load_ni)
    (!en_ni && down_i && q_o == '0) |=> (q_o == TOP));

  p_flag_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!load_ni)
    (max_min_o && !en_ni) |=> (!max_min_o || (down_i != $past(down_i))));

  generate
    if (DECADE) begin : g_dec_chk
      p_illegal_exit_r9: assert property (@(posedge clk_i) disable iff (!load_ni)
        (!en_ni && q_o > TOP) |=> (q_o == ($past(down_i) ? TOP : '0)));
      p_illegal_flag_r9: assert property (@(posedge clk_i) disable iff (!load_ni)
        (q_o > TOP) |-> !max_min_o);
    end
  endgenerate
endmodule

// File: tb/tb_udc_counter.sv
`timescale 1ns/1ps
module tb_udc_counter;
  logic       clk_i = 1'b0;
  logic       load_ni, en_ni, down_i;
  logic [3:0] data_i;
  logic [3:0] q_b, q_d;
  logic       mm_b, mm_d, rco_b, rco_d;

  always #2.5 clk_i = ~clk_i;

  udc_counter #(.WIDTH(4), .DECADE(1'b0)) dut (
    .clk_i(clk_i), .load_ni(load_ni), .data_i(data_i), .en_ni(en_ni), .down_i(down_i),
    .q_o(q_b), .max_min_o(mm_b), .rco_no(rco_b));

  udc_counter #(.WIDTH(4), .DECADE(1'b1)) dut_dec (
    .clk_i(clk_i), .load_ni(load_ni), .data_i(data_i), .en_ni(en_ni), .down_i(down_i),
    .q_o(q_d), .max_min_o(mm_d), .rco_no(rco_d));

  typedef struct {
    logic [3:0] qb; logic mb; logic rb;
    logic [3:0] qd; logic md; logic rd;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;
  logic [3:0] m_b, m_d;

  function automatic logic [3:0] mtop(bit dec);
    return dec ? 4'd9 : 4'd15;
  endfunction

  function automatic logic [3:0] mnext(logic [3:0] m, logic en_n, logic dn, bit dec);
    if (en_n) return m;
    if (!dn) return (m >= mtop(dec)) ? 4'd0 : m + 4'd1;
    if (m == 4'd0) return mtop(dec);
    if (m > mtop(dec)) return mtop(dec);
    return m - 4'd1;
  endfunction

  function automatic logic mterm(logic [3:0] m, logic dn, bit dec);
    return dn ? (m == 4'd0) : (m == mtop(dec));
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: set inputs in high phase, queue expected low-phase view
  task automatic cycle(logic en_n, logic dn, string tag);
    exp_t e;
    @(posedge clk_i);
    #1;
    en_ni  = en_n;
    down_i = dn;
    chk("R7", "rco_b high phase", rco_b, 1);
    chk("R7", "rco_d high phase", rco_d, 1);
    e.qb = m_b; e.mb = mterm(m_b, dn, 0); e.rb = ~(e.mb & ~en_n);
    e.qd = m_d; e.md = mterm(m_d, dn, 1); e.rd = ~(e.md & ~en_n);
    e.tag = tag;
    sb.push_back(e);
    m_b = mnext(m_b, en_n, dn, 0);
    m_d = mnext(m_d, en_n, dn, 1);
  endtask

  task automatic preset(logic [3:0] d);
    @(negedge clk_i);
    #1.5;
    load_ni = 1'b0;
    data_i  = d;
    #0.5;
    chk("R1", "q_b mid-phase load", q_b, d);
    chk("R1", "q_d mid-phase load", q_d, d);
    @(posedge clk_i);
    #1;
    chk("R2", "q_b after edge in load", q_b, d);
    chk("R2", "q_d after edge in load", q_d, d);
    en_ni   = 1'b1;
    load_ni = 1'b1;
    m_b = d;
    m_d = d;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "q_b", q_b, e.qb);
        chk("R6", "mm_b", mm_b, e.mb);
        chk("R7", "rco_b", rco_b, e.rb);
        chk(e.tag, "q_d", q_d, e.qd);
        chk("R6", "mm_d", mm_d, e.md);
        chk("R7", "rco_d", rco_d, e.rd);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    load_ni = 1'b0;
    data_i  = 4'd0;
    en_ni   = 1'b1;
    down_i  = 1'b0;
    #1;
    chk("R1", "q_b initial load", q_b, 0);
    chk("R1", "q_d initial load", q_d, 0);
    @(posedge clk_i);
    #1;
    load_ni = 1'b1;
    m_b = 4'd0;
    m_d = 4'd0;

    // R3 R8: up through both wraps
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, "R3");
    // R5: hold
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, "R5");
    // R4 R8: down through both wraps
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, "R4");

    // R7: parked at terminal with enable off gives flag but no pulse
    preset(4'd9);
    cycle(1'b1, 1'b0, "R7");
    cycle(1'b1, 1'b0, "R7");
    cycle(1'b0, 1'b0, "R8");
    preset(4'd0);
    cycle(1'b1, 1'b1, "R7");
    cycle(1'b0, 1'b1, "R8");
    cycle(1'b0, 1'b1, "R4");

    // R2: load held low across an edge with counting enabled
    @(posedge clk_i);
    #1;
    en_ni = 1'b0;
    down_i = 1'b0;
    preset(4'd6);
    cycle(1'b0, 1'b0, "R2");

    // R9: every illegal decade value, both directions
    for (int v = 10; v < 16; v++) begin
      preset(4'(v));
      cycle(1'b0, 1'b0, "R9");
      cycle(1'b0, 1'b0, "R9");
      preset(4'(v));
      cycle(1'b0, 1'b1, "R9");
      cycle(1'b0, 1'b1, "R9");
    end

    // direction flips in mid count
    preset(4'd8);
    for (int i = 0; i < 12; i++) cycle(1'b0, logic'(i % 3 == 0), "R6");

    repeat (3) @(posedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule